// File: doc/BRIEF.md
# Coarse-Fine Pulse Width Meter

This block measures how long an incoming pulse stays high. It combines two scales that run side by side. The coarse scale counts the rising edges of a fast reference clock that fall inside the pulse. The fine scale resolves the part of a clock period that the edge count cannot see. It does this from snapshots of a tapped inverter delay line, which reach the block as two tap vectors: one taken at the pulse's rising edge and one taken at its falling edge. With a short line of taps covering one clock period, the block reaches a long range at fine resolution, and it does so without a line as long as the full range.

Adjacent taps of an inverter chain have opposite polarity, so the block inverts every odd-indexed tap before decoding. Each corrected vector is then read as a thermometer code. The pulse input is asynchronous. It passes through a two-flop synchronizer before it gates the counter. That latency delays the start and the end of the pulse by the same amount, so the count is unaffected. The combined width code is presented with a single-cycle valid strobe.

A pulse is detected only if at least one reference edge falls inside it. Its width is then `count × NTAP + fine_start − fine_end` in delay-step units, where `fine_start` is the number of steps from the rising edge of the pulse to the next reference edge, and `fine_end` is the number of steps from the falling edge to the next reference edge.

Top module: `pw_meter`

## Requirements
- R1: The reported width equals C × NTAP + Fs − Fe. C is the number of reference-clock rising edges that occur while the pulse is high. Fs is the decoded start vector and Fe is the decoded stop vector. The default NTAP is 20 steps per reference period.
- R2: Phase correction inverts every tap at an odd index (bit 1, bit 3, …) before decoding. Taps at even indices are used as they are.
- R3: After correction, the fine code is the count of consecutive ones starting at bit 0. This is the position of the first 1-to-0 transition. A vector that is all ones decodes to NTAP, and a vector whose bit 0 is zero decodes to 0.
- R4: A bubble, meaning a zero followed by more ones at higher bits, is resolved by taking the lowest 1-to-0 transition. Ones above the first zero have no effect on the code.
- R5: `width_valid` is high for exactly one clock cycle per detected pulse. It rises within four clock cycles after the pulse falls.
- R6: The edge counter saturates at 2^CW−1 instead of wrapping. If the pulse holds more edges than that, `width_ovf` is asserted together with `width_valid`, and the width is computed from the saturated count. A pulse that holds exactly 2^CW−1 edges does not raise `width_ovf`.
- R7: A pulse shorter than one reference period that contains one edge reports a width below NTAP, taken from the fine difference NTAP + Fs − Fe.
- R8: While reset is active, and after it until the first measurement, `width_code`, `width_valid` and `width_ovf` are all zero.
- R9: `width_code` holds its value between valid strobes. Changes on the tap inputs while no pulse is being measured do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock; coarse scale counts its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse to be measured |
| start_taps | input | NTAP | Delay-line snapshot taken at the pulse's rising edge |
| stop_taps | input | NTAP | Delay-line snapshot taken at the pulse's falling edge |
| width_code | output | CW+FW+1 | Measured width in delay-step units |
| width_valid | output | 1 | One-cycle strobe marking a new width |
| width_ovf | output | 1 | Coarse count saturated during this measurement |

## Verification
The assertions check four rules on every cycle. The valid strobe lasts a single cycle. The overflow flag appears only together with valid. The result holds steady between strobes. A saturated counter stays at its maximum while the pulse persists. The bench supplies everything that depends on the arithmetic: the combined width over swept edge counts and start and stop fractions, phase correction, bubble resolution, short pulses, and the exact boundary between a full count and an overflowing one. The bench models the delay line behaviourally, placing the pulse edges at step offsets from the clock and encoding the matching tap vectors.

// File: rtl/pw_meter.sv
module pw_meter #(
  parameter int NTAP = 20,
  parameter int CW   = 8,
  localparam int FW  = $clog2(NTAP + 1),
  localparam int RW  = CW + FW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pulse_in,
  input  logic [NTAP-1:0] start_taps,
  input  logic [NTAP-1:0] stop_taps,
  output logic [RW-1:0]   width_code,
  output logic            width_valid,
  output logic            width_ovf
);
  localparam logic [CW-1:0] CMAX = '1;

  logic          s1, s2, s3;
  logic [CW-1:0] cnt;
  logic          ovf_r;
  logic [FW-1:0] fine_s;

  function automatic logic [FW-1:0] therm_decode(input logic [NTAP-1:0] raw);
    logic [NTAP-1:0] fixed;
    logic [FW-1:0]   code;
    for (int i = 0; i < NTAP; i++) fixed[i] = raw[i] ^ (i % 2 == 1);
    code = FW'(NTAP);
    for (int i = NTAP - 1; i >= 0; i--)
      if (!fixed[i]) code = FW'(i);
    return code;
  endfunction

  wire rise = s2 & ~s3;
  wire fall = ~s2 & s3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {pulse_in, s1, s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      ovf_r  <= 1'b0;
      fine_s <= '0;
    end else if (rise) begin
      cnt    <= CW'(1);
      ovf_r  <= 1'b0;
      fine_s <= therm_decode(start_taps);
    end else if (s2) begin
      if (cnt == CMAX) ovf_r <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      width_code  <= '0;
      width_valid <= 1'b0;
      width_ovf   <= 1'b0;
    end else if (fall) begin
      width_code  <= RW'(cnt) * RW'(NTAP) + RW'(fine_s) - RW'(therm_decode(stop_taps));
      width_valid <= 1'b1;
      width_ovf   <= ovf_r;
    end else begin
      width_valid <= 1'b0;
      width_ovf   <= 1'b0;
    end
endmodule

module pw_meter_chk #(
  parameter int CW = 8,
  parameter int RW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          width_valid,
  input logic          width_ovf,
  input logic [RW-1:0] width_code,
  input logic          s2,
  input logic          s3,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CMAX = '1;

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    width_valid |=> !width_valid);

  p_ovf_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    width_ovf |-> width_valid);

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !width_valid |-> $stable(width_code));

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && s2 && s3) |=> cnt == CMAX);
endmodule

bind pw_meter pw_meter_chk #(.CW(CW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .width_valid(width_valid), .width_ovf(width_ovf),
  .width_code(width_code), .s2(s2), .s3(s3), .cnt(cnt)
);

// File: tb/pw_meter_bench.sv
`timescale 1ns/1ps
module pw_meter_bench;
  localparam int NTAP = 20;
  localparam int CW   = 8;
  localparam int RW   = CW + $clog2(NTAP + 1) + 1;
  localparam real TCLK = 4.0;
  localparam real STEP = TCLK / NTAP;
  localparam logic [NTAP-1:0] ODD = 20'hAAAAA;

  logic clk = 0, rst_n = 0, pulse_in = 0;
  logic [NTAP-1:0] start_taps = '0, stop_taps = '0;
  logic [RW-1:0] width_code;
  logic width_valid, width_ovf;
  int checks = 0, errors = 0;

  always #(TCLK / 2) clk = ~clk;

  pw_meter u_pw_meter (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .start_taps(start_taps),
    .stop_taps(stop_taps), .width_code(width_code), .width_valid(width_valid),
    .width_ovf(width_ovf)
  );

  function automatic logic [NTAP-1:0] enc(input int n);
    logic [NTAP-1:0] t = '0;
    for (int i = 0; i < n; i++) t[i] = 1'b1;
    return t ^ ODD;
  endfunction

  function automatic int dec(input logic [NTAP-1:0] raw);
    logic [NTAP-1:0] c = raw ^ ODD;
    for (int i = 0; i < NTAP; i++) if (!c[i]) return i;
    return NTAP;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int c, input int fs, input int fe,
                         input logic [NTAP-1:0] sraw, input logic [NTAP-1:0] eraw,
                         input int ovf_exp, input string req);
    int found = 0;
    int exp_c = (c > 255) ? 255 : c;
    start_taps = sraw;
    stop_taps  = eraw;
    @(posedge clk);
    #(TCLK - fs * STEP);
    pulse_in = 1;
    #(fs * STEP + c * TCLK - fe * STEP);
    pulse_in = 0;
    for (int k = 0; k < 5 && !found; k++) begin
      @(negedge clk);
      if (width_valid) found = 1;
    end
    check({req, " valid within 4 cycles (R5)"}, found, 1);
    check({req, " width (R1)"}, width_code, exp_c * NTAP + dec(sraw) - dec(eraw));
    check({req, " overflow (R6)"}, width_ovf, ovf_exp);
    @(negedge clk);
    check({req, " valid single cycle (R5)"}, width_valid, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * TCLK);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [RW-1:0] held;
    repeat (3) @(negedge clk);
    check("R8 width at reset", width_code, 0);
    check("R8 valid at reset", width_valid, 0);
    check("R8 ovf at reset", width_ovf, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R8 width after reset", width_code, 0);

    for (int c = 1; c <= 4; c++)
      for (int fs = 1; fs < NTAP; fs += 3)
        for (int fe = 1; fe < NTAP; fe += 3)
          measure(c, fs, fe, enc(fs), enc(fe), 0, "R1 sweep");

    measure(12, 7, 3, enc(7), enc(3), 0, "R1 fifty-ns");
    check("R1 fifty-ns value", width_code, 12 * NTAP + 4);

    measure(1, 4, 15, enc(4), enc(15), 0, "R7 short");
    check("R7 short below one period", width_code, 9);

    measure(2, 5, 2, enc(5) | (20'h1 << 9) ^ (20'h1 << 9) | 20'h00C00, enc(2), 0, "R4 bubble");
    check("R4 bubble lowest transition", width_code, 2 * NTAP + 5 - 2);

    measure(2, 6, 2, ~enc(6) ^ ~ODD ^ ODD ^ ODD, enc(2), 0, "R2 uncorrected");
    check("R2 odd taps inverted", width_code, 2 * NTAP + 1 - 2);

    measure(1, 3, 3, {NTAP{1'b1}} ^ ODD, enc(3), 0, "R3 all ones");
    check("R3 all ones is NTAP", width_code, NTAP + NTAP - 3);
    measure(3, 3, 3, ODD, enc(0), 0, "R3 zero codes");
    check("R3 bit0 zero is 0", width_code, 3 * NTAP);

    held = width_code;
    start_taps = enc(11);
    stop_taps  = enc(1);
    repeat (6) @(negedge clk);
    check("R9 result held under tap changes", width_code, held);

    measure(255, 5, 5, enc(5), enc(5), 0, "R6 exact max");
    measure(260, 8, 2, enc(8), enc(2), 1, "R6 saturate");
    check("R6 saturated width", width_code, 255 * NTAP + 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule